// File: doc/BRIEF.md
# Serial Byte Receiver with Fill-Driven Ready-to-Send

This block takes an asynchronous serial line and turns each frame into a byte stored in a small receive queue. A frame is a low start bit, eight data bits with the least significant bit first, an optional parity bit, and one high stop bit. A free-running 16x oversampling tick from outside sets the bit timing. The receiver confirms the start bit at its midpoint and then samples every later bit once, near its centre. A received byte goes into the queue together with two error tags: one for a bad stop bit and one for a parity mismatch.

The block also drives an active-low ready-to-send line for the far transmitter. While the receiver is enabled and the queue holds fewer bytes than a level chosen by a 3-bit select, the line stays low, which lets the far end keep sending. When the queue reaches that level, or when the receiver is disabled, the line goes high. Software sees a sticky receive-data flag with its interrupt, and a sticky error interrupt that covers framing errors, parity errors and queue overrun. One clear strobe drops all of these flags. A read strobe removes the byte at the head of the queue.

Top module: `uart_rx_rts`

## Requirements
- R1: The receiver sees a start bit when it samples the line at 0 on a tick while idle. It then samples eight data bits, with D0 arriving first and stored in bit 0 of `rd_data`, and then the stop bit, each at the centre of its 16-tick bit period.
- R2: When `par_en` is 1, a parity bit follows D7. Its expected value is the XOR of the eight data bits, inverted when `par_odd` is 1. On a mismatch the byte is still stored, with `rd_perr` = 1, and the error interrupt rises.
- R3: If the line is back at 1 when the start bit is re-sampled eight ticks after detection, the event is a glitch. The receiver returns to idle and stores nothing.
- R4: A stop bit sampled as 0 is a framing error. The byte is still stored with `rd_ferr` = 1, and the error interrupt rises.
- R5: The queue holds up to 16 bytes in arrival order. `fill` gives the number stored, and `rd_data`, `rd_ferr` and `rd_perr` show the oldest byte. A one-cycle `rd_stb` removes that byte. A read strobe while the queue is empty leaves `fill` at 0.
- R6: A byte that completes while `fill` is 16 is discarded and the queue is left unchanged. The sticky `ovr` output is set and stays set until `clr_stb`.
- R7: While `rx_en` is 1, `rts_n` is 1 exactly when `fill` is at or above the level picked by `rts_sel`: 0→1, 1→4, 2→6, 3→8, 4→10, 5→12, 6→14, 7→15.
- R8: While `rx_en` is 0, `rts_n` is 1, and a frame on the line stores nothing.
- R9: `rdf` and `rxi_irq` go to 1 when a byte is stored and stay at 1 until `clr_stb`. `eri_irq` stays at 1 from a stored framing or parity error, or from an overrun, until `clr_stb`.
- R10: After reset, `fill`, `rdf`, `rxi_irq`, `eri_irq` and `ovr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | 16x oversampling tick, one cycle wide |
| rxd | input | 1 | Serial receive line, idles at 1 |
| rx_en | input | 1 | Receiver enable |
| par_en | input | 1 | Frame carries a parity bit |
| par_odd | input | 1 | Parity is odd when 1, even when 0 |
| rts_sel | input | 3 | Ready-to-send level select |
| rd_stb | input | 1 | Remove the head byte |
| clr_stb | input | 1 | Clear the data flag and error flags |
| rd_data | output | 8 | Head byte |
| rd_ferr | output | 1 | Head byte had a bad stop bit |
| rd_perr | output | 1 | Head byte had a parity mismatch |
| fill | output | 5 | Bytes held in the queue |
| rts_n | output | 1 | Ready-to-send, active low |
| rdf | output | 1 | Sticky receive-data flag |
| rxi_irq | output | 1 | Receive interrupt |
| eri_irq | output | 1 | Receive-error interrupt |
| ovr | output | 1 | Sticky overrun flag |

## Verification
The assertions assume that `rd_stb` and `clr_stb` are single-cycle strobes, and that the internal frame-complete pulse is the only event that can add to the queue. Under those assumptions, `fill` changes by at most one per cycle in either direction. They also assume the tick never comes faster than the two-stage line synchronizer can follow. The stimulus keeps to this. It changes the line only on a falling clock edge right after a tick, and it keeps each line level for sixteen ticks, with ticks four clocks apart. The strobes are raised for exactly one cycle, and never while a frame is being completed.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;

   localparam int DBITS = 8;

   typedef enum logic [2:0] {
      S_IDLE,
      S_START,
      S_DATA,
      S_PAR,
      S_STOP
   } rx_state_e;

   typedef struct packed {
      logic             perr;
      logic             ferr;
      logic [DBITS-1:0] data;
   } rx_word_t;

   // fill level at which the far end is asked to pause
   function automatic int unsigned rts_level(input logic [2:0] sel,
                                             input int unsigned depth);
      if (sel == 3'd0)      return 1;
      else if (sel == 3'd7) return depth - 1;
      else                  return 2 * int'(sel) + 2;
   endfunction

endpackage

// File: rtl/rx_frame.sv
`timescale 1ns/1ps
module rx_frame
   import uart_rx_pkg::*;
#(
   parameter int OSR        = 16,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  logic     tick,
   input  logic     rxd,
   input  logic     par_en,
   input  logic     par_odd,
   output logic     valid,
   output rx_word_t word
);

   localparam int CW = $clog2(OSR);
   localparam int BW = $clog2(DBITS);
   localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OSR - 1);
   localparam logic [BW-1:0] TOPB = BW'(DBITS - 1);

   rx_state_e        state;
   logic [CW-1:0]    cnt;
   logic [BW-1:0]    bidx;
   logic [DBITS-1:0] shift;
   logic             perr_q;
   logic             par_use;

   generate
      if (HAS_PARITY) begin : g_par
         assign par_use = par_en;
      end else begin : g_nopar
         assign par_use = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         cnt    <= '0;
         bidx   <= '0;
         shift  <= '0;
         perr_q <= 1'b0;
         valid  <= 1'b0;
         word   <= '0;
      end else begin
         valid <= 1'b0;
         if (!en) begin
            state <= S_IDLE;
            cnt   <= '0;
         end else if (tick) begin
            case (state)
               S_IDLE: begin
                  if (!rxd) begin
                     state <= S_START;
                     cnt   <= '0;
                  end
               end
               S_START: begin
                  if (cnt == MID) begin
                     cnt    <= '0;
                     bidx   <= '0;
                     perr_q <= 1'b0;
                     state  <= rxd ? S_IDLE : S_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               S_DATA: begin
                  if (cnt == LAST) begin
                     cnt   <= '0;
                     shift <= {rxd, shift[DBITS-1:1]};
                     bidx  <= bidx + 1'b1;
                     if (bidx == TOPB) state <= par_use ? S_PAR : S_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               S_PAR: begin
                  if (cnt == LAST) begin
                     cnt    <= '0;
                     perr_q <= rxd ^ (^shift) ^ par_odd;
                     state  <= S_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               S_STOP: begin
                  if (cnt == LAST) begin
                     cnt   <= '0;
                     word  <= '{perr: perr_q, ferr: ~rxd, data: shift};
                     valid <= 1'b1;
                     state <= S_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= S_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/rx_fifo.sv
`timescale 1ns/1ps
module rx_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 10
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               wdata,
   input  logic                       pop,
   output logic [W-1:0]               rdata,
   output logic [$clog2(DEPTH):0]     count,
   output logic                       full
);

   localparam int AW = $clog2(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   assign full    = (count == (AW+1)'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && (count != '0);
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/rx_flow.sv
`timescale 1ns/1ps
module rx_flow
   import uart_rx_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic [2:0]             sel,
   input  logic [$clog2(DEPTH):0] count,
   input  logic                   stored,
   input  logic                   dropped,
   input  logic                   ferr_in,
   input  logic                   perr_in,
   input  logic                   clr,
   output logic                   rts_n,
   output logic                   rdf,
   output logic                   ovr,
   output logic                   err_any
);

   localparam int CNTW = $clog2(DEPTH) + 1;

   logic [CNTW-1:0] level;
   logic            ferr_stk, perr_stk;

   assign level   = CNTW'(rts_level(sel, DEPTH));
   assign rts_n   = !en || (count >= level);
   assign err_any = ferr_stk | perr_stk | ovr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdf      <= 1'b0;
         ovr      <= 1'b0;
         ferr_stk <= 1'b0;
         perr_stk <= 1'b0;
      end else begin
         rdf      <= stored | (rdf & ~clr);
         ovr      <= dropped | (ovr & ~clr);
         ferr_stk <= (stored & ferr_in) | (ferr_stk & ~clr);
         perr_stk <= (stored & perr_in) | (perr_stk & ~clr);
      end
   end

endmodule

// File: rtl/uart_rx_rts.sv
`timescale 1ns/1ps
module uart_rx_rts
   import uart_rx_pkg::*;
#(
   parameter int DEPTH      = 16,
   parameter int OSR        = 16,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   os_tick,
   input  logic                   rxd,
   input  logic                   rx_en,
   input  logic                   par_en,
   input  logic                   par_odd,
   input  logic [2:0]             rts_sel,
   input  logic                   rd_stb,
   input  logic                   clr_stb,
   output logic [7:0]             rd_data,
   output logic                   rd_ferr,
   output logic                   rd_perr,
   output logic [$clog2(DEPTH):0] fill,
   output logic                   rts_n,
   output logic                   rdf,
   output logic                   rxi_irq,
   output logic                   eri_irq,
   output logic                   ovr
);

   localparam int WW = $bits(rx_word_t);

   generate
      if (DEPTH < 16 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 16");
      end
      if (OSR < 4 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
         $error("OSR must be a power of two of at least 4");
      end
   endgenerate

   logic [1:0] rxd_sy;
   logic       frm_valid;
   rx_word_t   frm_word;
   rx_word_t   head;
   logic       ff_full;
   logic       err_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rxd_sy <= 2'b11;
      else        rxd_sy <= {rxd_sy[0], rxd};
   end

   rx_frame #(.OSR(OSR), .HAS_PARITY(HAS_PARITY)) u_frm (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (rx_en),
      .tick    (os_tick),
      .rxd     (rxd_sy[1]),
      .par_en  (par_en),
      .par_odd (par_odd),
      .valid   (frm_valid),
      .word    (frm_word)
   );

   rx_fifo #(.DEPTH(DEPTH), .W(WW)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (frm_valid),
      .wdata (frm_word),
      .pop   (rd_stb),
      .rdata (head),
      .count (fill),
      .full  (ff_full)
   );

   rx_flow #(.DEPTH(DEPTH)) u_flow (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (rx_en),
      .sel     (rts_sel),
      .count   (fill),
      .stored  (frm_valid & ~ff_full),
      .dropped (frm_valid & ff_full),
      .ferr_in (frm_word.ferr),
      .perr_in (frm_word.perr),
      .clr     (clr_stb),
      .rts_n   (rts_n),
      .rdf     (rdf),
      .ovr     (ovr),
      .err_any (err_any)
   );

   assign rd_data = head.data;
   assign rd_ferr = head.ferr;
   assign rd_perr = head.perr;
   assign rxi_irq = rdf;
   assign eri_irq = err_any;

endmodule

// File: rtl/uart_rx_rts_chk.sv
`timescale 1ns/1ps
module uart_rx_rts_chk #(
   parameter int DEPTH = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   rx_en,
   input logic                   rd_stb,
   input logic                   clr_stb,
   input logic [$clog2(DEPTH):0] fill,
   input logic                   rts_n,
   input logic                   rdf,
   input logic                   ovr,
   input logic                   push
);

   localparam int CNTW = $clog2(DEPTH) + 1;

   p_fill_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CNTW'(DEPTH));

   p_pop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && fill != '0 && !push |=> fill == $past(fill) - 1'b1);

   p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fill == CNTW'(DEPTH) && !rd_stb |=> fill == CNTW'(DEPTH));

   p_ovr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      push && fill == CNTW'(DEPTH) |=> ovr);

   p_ovr_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovr && !clr_stb |=> ovr);

   p_rts_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fill == CNTW'(DEPTH) |-> rts_n);

   p_rts_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_en && fill == '0 |-> !rts_n);

   p_rts_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |-> rts_n);

   p_dis_nopush_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !push);

   p_rdf_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rdf && !clr_stb |=> rdf);

   p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb && !push |=> !rdf && !ovr);

endmodule

bind uart_rx_rts uart_rx_rts_chk #(.DEPTH(DEPTH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rx_en   (rx_en),
   .rd_stb  (rd_stb),
   .clr_stb (clr_stb),
   .fill    (fill),
   .rts_n   (rts_n),
   .rdf     (rdf),
   .ovr     (ovr),
   .push    (frm_valid)
);

// File: tb/sim_uart_rx_rts.sv
`timescale 1ns/1ps
module sim_uart_rx_rts;

   localparam int DEPTH = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       rxd = 1'b1;
   logic       rx_en = 1'b0;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic [2:0] sel = 3'd0;
   logic       rd_stb = 1'b0;
   logic       clr_stb = 1'b0;
   logic [7:0] rd_data;
   logic       rd_ferr, rd_perr;
   logic [4:0] fill;
   logic       rts_n, rdf, rxi_irq, eri_irq, ovr;

   int checks = 0;
   int errors = 0;
   bit mon_on = 1'b0;

   logic [9:0] q[$];
   bit e_rdf = 0, e_ovr = 0, e_err = 0;

   always #4 clk = ~clk;

   uart_rx_rts u0 (
      .clk(clk), .rst_n(rst_n), .os_tick(tick), .rxd(rxd), .rx_en(rx_en),
      .par_en(par_en), .par_odd(par_odd), .rts_sel(sel), .rd_stb(rd_stb),
      .clr_stb(clr_stb), .rd_data(rd_data), .rd_ferr(rd_ferr), .rd_perr(rd_perr),
      .fill(fill), .rts_n(rts_n), .rdf(rdf), .rxi_irq(rxi_irq),
      .eri_irq(eri_irq), .ovr(ovr)
   );

   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", what, act, exp);
      end
   endtask

   function automatic int lvl(input int s);
      case (s)
         0: return 1;   1: return 4;   2: return 6;   3: return 8;
         4: return 10;  5: return 12;  6: return 14;  default: return 15;
      endcase
   endfunction

   initial begin
      forever begin
         repeat (3) @(negedge clk);
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   end

   // every-clock reference for the ready-to-send line
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (mon_on) begin
            if (!rx_en) chk("R8 rts_n while disabled", rts_n, 1);
            else        chk("R7 rts_n against level", rts_n, (int'(fill) >= lvl(int'(sel))) ? 1 : 0);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk("R1 watchdog expired", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic wait_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         while (!tick) @(posedge clk);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      rxd = b;
      wait_ticks(16);
   endtask

   task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop_v);
      logic pe;
      pe = par_en ? bad_par : 1'b0;
      send_bit(1'b0);
      for (int i = 0; i < 8; i++) send_bit(d[i]);
      if (par_en) send_bit((^d) ^ par_odd ^ bad_par);
      send_bit(stop_v);
      @(negedge clk);
      rxd = 1'b1;
      wait_ticks(16);
      if (rx_en) begin
         if (q.size() < DEPTH) begin
            q.push_back({pe, ~stop_v, d});
            e_rdf = 1;
            if (pe || !stop_v) e_err = 1;
         end else begin
            e_ovr = 1;
         end
      end
   endtask

   task automatic check_state(input string r);
      @(negedge clk);
      chk({r, " fill"}, int'(fill), q.size());
      if (q.size() > 0) begin
         chk({r, " head data"}, int'(rd_data), int'(q[0][7:0]));
         chk({r, " head ferr"}, int'(rd_ferr), int'(q[0][8]));
         chk({r, " head perr"}, int'(rd_perr), int'(q[0][9]));
      end
      chk({r, " R9 rdf"}, int'(rdf), int'(e_rdf));
      chk({r, " R9 rxi_irq"}, int'(rxi_irq), int'(e_rdf));
      chk({r, " R6 ovr"}, int'(ovr), int'(e_ovr));
      chk({r, " R9 eri_irq"}, int'(eri_irq), int'(e_err || e_ovr));
   endtask

   task automatic pop_one();
      @(negedge clk);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      if (q.size() > 0) void'(q.pop_front());
   endtask

   task automatic clear_flags();
      @(negedge clk);
      clr_stb = 1'b1;
      @(negedge clk);
      clr_stb = 1'b0;
      e_rdf = 0; e_ovr = 0; e_err = 0;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      chk("R10 fill after reset", int'(fill), 0);
      chk("R10 rdf after reset", int'(rdf), 0);
      chk("R10 rxi_irq after reset", int'(rxi_irq), 0);
      chk("R10 eri_irq after reset", int'(eri_irq), 0);
      chk("R10 ovr after reset", int'(ovr), 0);
      rst_n = 1'b1;
      rx_en = 1'b1;
      mon_on = 1'b1;

      // R1: plain frames, varied bit patterns
      send_frame(8'hA5, 0, 1); check_state("R1 a5");
      send_frame(8'h3C, 0, 1); check_state("R1 3c");
      send_frame(8'h01, 0, 1); check_state("R1 01");
      send_frame(8'hFF, 0, 1); check_state("R1 ff");
      for (int i = 0; i < 4; i++) begin
         pop_one();
         check_state("R5 pop order");
      end
      clear_flags();

      // R2: parity, even then odd, good and bad
      par_en = 1'b1;
      par_odd = 1'b0;
      send_frame(8'h5A, 0, 1); check_state("R2 even good");
      send_frame(8'h5B, 1, 1); check_state("R2 even bad");
      par_odd = 1'b1;
      send_frame(8'h77, 0, 1); check_state("R2 odd good");
      send_frame(8'h80, 1, 1); check_state("R2 odd bad");
      clear_flags();
      check_state("R9 cleared");
      while (q.size() > 0) begin
         pop_one();
         check_state("R5 drain parity");
      end
      par_en = 1'b0;

      // R4: framing error kept with tag
      send_frame(8'h42, 0, 0); check_state("R4 framing");
      clear_flags();
      check_state("R9 clear after framing");
      pop_one();
      check_state("R5 after pop");

      // R3: short low pulse rejected
      @(negedge clk);
      rxd = 1'b0;
      wait_ticks(3);
      @(negedge clk);
      rxd = 1'b1;
      wait_ticks(32);
      check_state("R3 glitch");

      // R5: read strobe while empty
      pop_one();
      check_state("R5 empty pop");

      // R7: fill to the top, sweep every level select at each count
      for (int n = 0; n < DEPTH; n++) begin
         send_frame(8'(n * 7 + 3), 0, 1);
         for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            sel = 3'(s);
         end
         @(negedge clk);
      end
      sel = 3'd7;
      check_state("R7 full");

      // R6: one more byte is dropped
      send_frame(8'hC3, 0, 1); check_state("R6 overrun");
      clear_flags();
      check_state("R6 overrun cleared");
      while (q.size() > 0) begin
         pop_one();
         check_state("R5 drain full");
      end
      clear_flags();

      // R8: disabled receiver ignores a frame
      rx_en = 1'b0;
      send_frame(8'h99, 0, 1);
      check_state("R8 disabled frame");
      chk("R8 rts_n disabled", int'(rts_n), 1);
      rx_en = 1'b1;
      send_frame(8'h66, 0, 1); check_state("R8 re-enabled");

      mon_on = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule